// File: doc/BRIEF.md
# Dual-channel reference-compare timer pair

Two 16-bit up-counters share one configuration byte and a flat register bus. Each channel chooses its count source: the system clock every cycle, the system clock divided by sixteen, or the match pulses of its partner channel. That source passes through two 8-bit divide stages in a row before it advances the counter. When a count step arrives while the counter equals the channel's reference value, the channel latches a match event. On that same step the counter either returns to zero or keeps climbing, as a mode bit selects. Each channel drives its own interrupt line from the latched event.

Software stops and clears a channel through the shared byte. It then loads the divide values, the mode, the start count and the reference, and clears stale events by writing ones to them. Releasing the stop bit starts counting. The asynchronous active-low reset is released to the logic through a two-stage synchronizer. Registers therefore start to follow bus writes on the third rising edge after `rst_n` goes high.

Top module: `dual_ref_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low.
- R2: Register map (word address on `reg_addr`): 0 configuration, 1/2 mode of channel 0/1, 3/4 reference, 5/6 counter, 7/8 event, 9/10 primary divide (bits 7:0). Every other address reads 0 and ignores writes.
- R3: Configuration bit 1 (channel 0) and bit 5 (channel 1) are stop bits. They read back as written. While a channel's stop bit is 1, its counter and all of its divide stages hold their values.
- R4: Configuration bit 0 (channel 0) and bit 4 (channel 1) are one-shot clears. Writing 1 zeroes that channel's counter and its divide stages at that edge. These bits always read 0.
- R5: Mode bits 2:1 pick the count source. 1 and 3 select the clock every cycle. 2 selects the clock divided by 16. 0 selects the partner channel's match pulses, each of which counts one cycle after the partner's match.
- R6: Primary divide P (register bits 7:0) and secondary divide S (mode bits 15:8) give one count step per (P+1)·(S+1) source pulses. With source 2 that is 16·(P+1)·(S+1) clocks.
- R7: When a count step arrives while the counter equals the reference, event bit 1 is set. If mode bit 3 is 1 the counter goes to 0. Otherwise it increments and wraps modulo 2^16.
- R8: Writing the event register clears each event bit written with 1 and leaves bits written with 0 unchanged. A match in the same cycle wins over the clear. Event bits other than bit 1 always read 0.
- R9: The interrupt of a channel is high exactly when its mode bit 4 and its event bit 1 are both 1.
- R10: A write to the counter loads the written value. Any count step in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
A bus write lands on the next rising edge. A counter, event or interrupt change caused by a count step shows up on the edge that consumes the step. Cascaded steps trail the partner's match by one more edge. Read data is combinational, so the bench drives the address after a falling edge and samples one nanosecond later. It checks the interrupt lines 2 ns after each rising edge, against a behavioural model that is updated on that same edge from the same bus inputs. The model also holds the synchronizer's two-edge release delay.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  parameter int REG_W    = 16;
  parameter int CNT_W    = REG_W;
  parameter int PSC_W    = 8;
  parameter int ADDR_W   = 4;
  parameter int NCH      = 2;
  parameter int SLOW_DIV = 16;
  localparam int SLOW_W  = $clog2(SLOW_DIV);

  // word addresses; channel c adds c to each per-channel base
  localparam int A_CFG  = 0;
  localparam int A_MODE = 1;
  localparam int A_REF  = 3;
  localparam int A_CNT  = 5;
  localparam int A_EVT  = 7;
  localparam int A_PSR  = 9;

  // configuration byte: channel c uses bit 4c (clear) and 4c+1 (stop)
  localparam int CFG_STRIDE = 4;
  localparam int CFG_CLR    = 0;
  localparam int CFG_STOP   = 1;

  // mode register fields
  localparam int MODE_SEL_LO  = 1;
  localparam int MODE_RESTART = 3;
  localparam int MODE_IRQ_EN  = 4;
  localparam int MODE_PSC_LO  = 8;

  localparam int EVT_MATCH = 1;

  typedef enum logic [1:0] {
    CS_CASCADE  = 2'd0,
    CS_INTERNAL = 2'd1,
    CS_SLOW     = 2'd2,
    CS_INT_ALT  = 2'd3
  } clk_sel_e;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  always_comb begin
    wrap   = (cnt_q >= div_i);
    tick_o = adv_i & wrap;
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] mode_i,
  input  logic [PSC_W-1:0] psr_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             evt_clr_i,
  input  logic             casc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [REG_W-1:0] evt_o,
  output logic             match_o,
  output logic             irq_o
);
  clk_sel_e         sel;
  logic             run, slow_adv, slow_tick, src, pri_adv, pri_tick, sec_tick;
  logic             cnt_en, hit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, match_q;
  logic             unused_mode;

  assign unused_mode = ^{mode_i[7:5], mode_i[0]};

  always_comb begin
    sel      = clk_sel_e'(mode_i[MODE_SEL_LO +: 2]);
    run      = ~stop_i;
    slow_adv = run & (sel == CS_SLOW);
    case (sel)
      CS_CASCADE: src = casc_i;
      CS_SLOW:    src = slow_tick;
      default:    src = 1'b1;
    endcase
    pri_adv = run & src;
  end

  dtmr_prescale #(.W(SLOW_W)) u_slow (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(slow_adv),
    .div_i(SLOW_W'(SLOW_DIV - 1)), .tick_o(slow_tick));

  dtmr_prescale #(.W(PSC_W)) u_pri (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(pri_adv),
    .div_i(psr_i), .tick_o(pri_tick));

  dtmr_prescale #(.W(PSC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(pri_tick),
    .div_i(mode_i[MODE_PSC_LO +: PSC_W]), .tick_o(sec_tick));

  always_comb begin
    cnt_en = sec_tick & ~clr_i & ~cnt_we_i;
    hit    = cnt_en & (cnt_q == ref_i);
    cnt_d  = cnt_q;
    if (clr_i)                              cnt_d = '0;
    else if (cnt_we_i)                      cnt_d = cnt_wdata_i;
    else if (hit && mode_i[MODE_RESTART])   cnt_d = '0;
    else if (cnt_en)                        cnt_d = cnt_q + 1'b1;
    flag_d = (flag_q & ~evt_clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
      match_q <= hit;
    end
  end

  always_comb begin
    evt_o            = '0;
    evt_o[EVT_MATCH] = flag_q;
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign irq_o   = mode_i[MODE_IRQ_EN] & flag_q;
endmodule

// File: rtl/dual_ref_timer.sv
module dual_ref_timer
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    irq
);
  logic [1:0]                 rst_sync_q;
  logic                       rst_n_s;
  logic [NCH-1:0]             stop_q, stop_d, clr;
  logic [NCH-1:0][REG_W-1:0]  mode_q, mode_d;
  logic [NCH-1:0][CNT_W-1:0]  ref_q, ref_d;
  logic [NCH-1:0][PSC_W-1:0]  psr_q, psr_d;
  logic [NCH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NCH-1:0][REG_W-1:0]  ch_evt;
  logic [NCH-1:0]             ch_match, cnt_we, evt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb begin
    stop_d = stop_q;
    mode_d = mode_q;
    ref_d  = ref_q;
    psr_d  = psr_q;
    for (int c = 0; c < NCH; c++) begin
      clr[c]     = reg_we && (reg_addr == ADDR_W'(A_CFG)) &&
                   reg_wdata[CFG_STRIDE*c + CFG_CLR];
      cnt_we[c]  = reg_we && (reg_addr == ADDR_W'(A_CNT + c));
      evt_clr[c] = reg_we && (reg_addr == ADDR_W'(A_EVT + c)) &&
                   reg_wdata[EVT_MATCH];
      if (reg_we && (reg_addr == ADDR_W'(A_CFG)))
        stop_d[c] = reg_wdata[CFG_STRIDE*c + CFG_STOP];
      if (reg_we && (reg_addr == ADDR_W'(A_MODE + c))) mode_d[c] = reg_wdata;
      if (reg_we && (reg_addr == ADDR_W'(A_REF + c)))  ref_d[c]  = reg_wdata;
      if (reg_we && (reg_addr == ADDR_W'(A_PSR + c)))  psr_d[c]  = reg_wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stop_q <= '0;
      mode_q <= '0;
      ref_q  <= '0;
      psr_q  <= '0;
    end else begin
      stop_q <= stop_d;
      mode_q <= mode_d;
      ref_q  <= ref_d;
      psr_q  <= psr_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int PARTNER = NCH - 1 - c;
    dtmr_channel u_ch (
      .clk(clk), .rst_n(rst_n_s),
      .stop_i(stop_q[c]), .clr_i(clr[c]),
      .mode_i(mode_q[c]), .psr_i(psr_q[c]), .ref_i(ref_q[c]),
      .cnt_we_i(cnt_we[c]), .cnt_wdata_i(reg_wdata),
      .evt_clr_i(evt_clr[c]), .casc_i(ch_match[PARTNER]),
      .cnt_o(ch_cnt[c]), .evt_o(ch_evt[c]),
      .match_o(ch_match[c]), .irq_o(irq[c]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == ADDR_W'(A_CFG))
        reg_rdata[CFG_STRIDE*c + CFG_STOP] = stop_q[c];
      if (reg_addr == ADDR_W'(A_MODE + c)) reg_rdata = mode_q[c];
      if (reg_addr == ADDR_W'(A_REF + c))  reg_rdata = ref_q[c];
      if (reg_addr == ADDR_W'(A_CNT + c))  reg_rdata = ch_cnt[c];
      if (reg_addr == ADDR_W'(A_EVT + c))  reg_rdata = ch_evt[c];
      if (reg_addr == ADDR_W'(A_PSR + c))
        reg_rdata = {{(REG_W-PSC_W){1'b0}}, psr_q[c]};
    end
  end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_we,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [REG_W-1:0]          reg_wdata,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0][REG_W-1:0] ch_evt,
  input logic [NCH-1:0]            stop_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic touch;
    assign touch = reg_we && ((reg_addr == ADDR_W'(A_CFG)) ||
                              (reg_addr == ADDR_W'(A_CNT + c)));

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q[c] && !touch) |=> $stable(ch_cnt[c])); // R3

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_CFG) && reg_wdata[CFG_STRIDE*c + CFG_CLR])
      |=> (ch_cnt[c] == '0)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !touch |=> (ch_cnt[c] == $past(ch_cnt[c]) ||
                  ch_cnt[c] == $past(ch_cnt[c]) + 1'b1 ||
                  ch_cnt[c] == '0)); // R7

    AST_EVT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt[c][0] == 1'b0 && ch_evt[c][REG_W-1:2] == '0)); // R8

    AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> ch_evt[c][EVT_MATCH]); // R9
  end
endmodule

bind dual_ref_timer dtmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .ch_cnt(ch_cnt), .ch_evt(ch_evt),
  .stop_q(stop_q));

// File: tb/dual_ref_timer_tb_top.sv
`timescale 1ns/1ps
module dual_ref_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_ref_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  // behavioural reference model
  int rs;
  int m_stop[2], m_mode[2], m_ref[2], m_psr[2];
  int m_cnt[2], m_evt[2], m_pc[2], m_sc[2], m_slow[2], m_match[2];
  int n_cnt[2], n_evt[2], n_pc[2], n_sc[2], n_slow[2], n_match[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs = 0;
      for (int c = 0; c < 2; c++) begin
        m_stop[c] = 0; m_mode[c] = 0; m_ref[c] = 0; m_psr[c] = 0;
        m_cnt[c] = 0; m_evt[c] = 0; m_pc[c] = 0; m_sc[c] = 0;
        m_slow[c] = 0; m_match[c] = 0;
      end
    end else if (rs < 2) begin
      rs = rs + 1;
    end else begin
      for (int c = 0; c < 2; c++) begin
        int sel, sdiv; bit run, clr, cw, slow_t, src, padv, p_t, s_t, cen, hit;
        sel    = (m_mode[c] >> 1) & 3;
        run    = (m_stop[c] == 0);
        clr    = we && addr == 0 && wdata[4*c];
        cw     = we && addr == 4'(5 + c);
        slow_t = run && sel == 2 && m_slow[c] >= 15;
        src    = (sel == 0) ? (m_match[1-c] != 0) : (sel == 2) ? slow_t : 1'b1;
        padv   = run && src;
        p_t    = padv && m_pc[c] >= m_psr[c];
        sdiv   = (m_mode[c] >> 8) & 255;
        s_t    = p_t && m_sc[c] >= sdiv;
        cen    = s_t && !clr && !cw;
        hit    = cen && m_cnt[c] == m_ref[c];
        n_slow[c] = clr ? 0 : (run && sel == 2) ? (m_slow[c] >= 15 ? 0 : m_slow[c] + 1) : m_slow[c];
        n_pc[c]   = clr ? 0 : padv ? (p_t ? 0 : m_pc[c] + 1) : m_pc[c];
        n_sc[c]   = clr ? 0 : p_t ? (s_t ? 0 : m_sc[c] + 1) : m_sc[c];
        if (clr)                                n_cnt[c] = 0;
        else if (cw)                            n_cnt[c] = wdata;
        else if (hit && ((m_mode[c] >> 3) & 1)) n_cnt[c] = 0;
        else if (cen)                           n_cnt[c] = (m_cnt[c] + 1) & 16'hFFFF;
        else                                    n_cnt[c] = m_cnt[c];
        n_evt[c]   = ((m_evt[c] != 0) && !(we && addr == 4'(7 + c) && wdata[1])) || hit;
        n_match[c] = hit;
      end
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = n_cnt[c]; m_evt[c] = n_evt[c]; m_pc[c] = n_pc[c];
        m_sc[c] = n_sc[c]; m_slow[c] = n_slow[c]; m_match[c] = n_match[c];
        if (we && addr == 0)          m_stop[c] = wdata[4*c+1];
        if (we && addr == 4'(1 + c))  m_mode[c] = wdata;
        if (we && addr == 4'(3 + c))  m_ref[c]  = wdata;
        if (we && addr == 4'(9 + c))  m_psr[c]  = wdata & 16'hFF;
      end
    end
  end

  function automatic logic [15:0] mdl_read(input logic [3:0] a);
    case (a)
      4'd0: return 16'((m_stop[0] << 1) | (m_stop[1] << 5));
      4'd1, 4'd2:  return 16'(m_mode[a-1]);
      4'd3, 4'd4:  return 16'(m_ref[a-3]);
      4'd5, 4'd6:  return 16'(m_cnt[a-5]);
      4'd7, 4'd8:  return 16'(m_evt[a-7] << 1);
      4'd9, 4'd10: return 16'(m_psr[a-9]);
      default:     return 16'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // R9: interrupt lines compared with the model on every clock
  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      for (int c = 0; c < 2; c++)
        check("R9 irq", {15'd0, irq[c]},
              {15'd0, ((m_mode[c] >> 4) & 1) != 0 && m_evt[c] != 0});
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, mdl_read(a));
  endtask

  task automatic watch(input string tag, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      rd(tag, 4'd5);
      rd(tag, 4'd7);
      rd(tag, 4'd6);
      rd(tag, 4'd8);
    end
  endtask

  task automatic setup0(input logic [15:0] mode, input logic [15:0] rf, input logic [7:0] psr);
    wr(4'd0, 16'h0023);       // stop and clear channel 0, stop channel 1
    wr(4'd9, {8'd0, psr});
    wr(4'd1, mode);
    wr(4'd5, 16'd0);
    wr(4'd3, rf);
    wr(4'd7, 16'hFFFF);
    wr(4'd0, 16'h0020);       // release channel 0
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1, R2: reset values over the full map, including unused addresses
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); addr = 4'(a); #1;
      check("R1 reset value", rdata, 16'h0000);
    end
    check("R1 irq reset", {14'd0, irq}, 16'h0000);

    // R7, R9: restart at reference, interrupt enabled
    setup0(16'h001A, 16'd5, 8'd0);
    watch("R7 restart", 20);

    // R8: zero bits do not clear, one bit clears
    wr(4'd0, 16'h0022);
    wr(4'd7, 16'h0000);
    rd("R8 zero write keeps", 4'd7);
    wr(4'd7, 16'hFFFD);
    rd("R8 other bits keep", 4'd7);
    wr(4'd7, 16'h0002);
    rd("R8 clear", 4'd7);
    check("R8 cleared literal", rdata, 16'h0000);

    // R7: free running past the reference
    setup0(16'h0012, 16'd3, 8'd0);
    watch("R7 free run", 12);

    // R6: both divide stages
    setup0(16'h011A, 16'd2, 8'd2);
    watch("R6 prescale", 25);

    // R5, R6: slow source
    setup0(16'h001C, 16'd1, 8'd1);
    watch("R5 slow", 40);

    // R5: source 3 behaves as the plain clock
    setup0(16'h001E, 16'd4, 8'd0);
    watch("R5 alt internal", 10);

    // R5: channel 1 counts channel 0 matches
    setup0(16'h001A, 16'd2, 8'd0);
    wr(4'd0, 16'h0022);
    wr(4'd2, 16'h0018);
    wr(4'd6, 16'd0);
    wr(4'd4, 16'd1);
    wr(4'd8, 16'hFFFF);
    wr(4'd0, 16'h0000);
    watch("R5 cascade", 30);

    // R3: stop holds
    wr(4'd0, 16'h0022);
    rd("R3 stop readback", 4'd0);
    check("R3 stop literal", rdata, 16'h0022);
    watch("R3 stopped", 8);
    wr(4'd0, 16'h0000);
    watch("R3 resumed", 4);

    // R4: one-shot clear, not stored
    wr(4'd0, 16'h0013);
    rd("R4 clear cnt", 4'd5);
    check("R4 cnt literal", rdata, 16'h0000);
    rd("R4 clear readback", 4'd0);
    check("R4 cfg literal", rdata, 16'h0002);

    // R10: counter load while running
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'h1234);
    watch("R10 load", 3);

    // R7: 16-bit wrap in free run, match at zero
    setup0(16'h0012, 16'h0000, 8'd0);
    wr(4'd5, 16'hFFFD);
    watch("R7 wrap", 6);

    // R9: interrupt disabled while event sets
    setup0(16'h000A, 16'd1, 8'd0);
    watch("R9 irq masked", 6);
    rd("R9 event set", 4'd7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule